// File: doc/BRIEF.md
# Variable Bit Field Unit

This block performs one field operation per request on a bit field of 1 to 32 bits. The field lives inside a 64-bit window made of two adjacent 32-bit words. It can start at any of 32 bit positions, so it may straddle the boundary between the two words. A single alignment shifter serves all eight operations:

- unsigned extract and signed extract;
- a search for the first set bit;
- a status-only test;
- insert;
- invert, clear and set of the whole field.

Surrounding logic fetches the two words, presents them together with the offset, width code, operation and insert value, and pulses a valid strobe. One cycle later the block returns:

- the rewritten window, for the caller to store back;
- a 32-bit result;
- sign and zero flags, which describe the field as it was before any change.

Decoding of instructions and memory access belong to the surrounding logic.

Top module: `bitFieldUnit`

## Requirements
- R1: The width code selects a field of 1 to 31 bits, and code 0 selects 32 bits. Offsets 0 to 31 count from the window's most significant bit: offset 0 names window bit 63. The field covers window bits 63-offset down to 64-offset-width, and may cross bit 32.
- R2: The operation code is decoded as follows: 0 unsigned extract, 1 signed extract, 2 find first set, 3 test, 4 insert, 5 invert, 6 clear, 7 set.
- R3: Unsigned extract returns the field right-justified, with zeros above it.
- R4: Signed extract returns the field right-justified, with every bit above it equal to the field's top bit.
- R5: Insert places the low width bits of the insert value into the field and leaves every other window bit as it was.
- R6: Find first set returns offset plus the distance, counted from the field's most significant end, of the first 1 bit. When the field holds no 1, it returns offset plus width.
- R7: Invert complements every field bit, clear zeroes every field bit, and set drives every field bit to 1. All window bits outside the field are unchanged.
- R8: Unsigned extract, signed extract, find first set and test return the window unchanged. Test, insert, invert, clear and set return the unsigned field value as it was before the operation.
- R9: The sign flag equals the field's top bit before modification. The zero flag is 1 exactly when the field was all zeros before modification.
- R10: All outputs update at the clock edge that samples the valid strobe, and the done output is high for exactly that following cycle. Without a strobe, the window, result and flags hold their values.
- R11: While reset is asserted, the done output, window, result and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe, one cycle per operation |
| opCode | input | 3 | Field operation select |
| bitOffset | input | 5 | Field start, counted from window MSB |
| fieldWidth | input | 5 | Field width code, 0 means 32 |
| window | input | 64 | Two adjacent words holding the field |
| insertVal | input | 32 | Value whose low bits are inserted |
| doneValid | output | 1 | Result valid pulse |
| winOut | output | 64 | Window after the operation |
| result | output | 32 | Extracted value, search result or prior field |
| flagN | output | 1 | Field top bit before modification |
| flagZ | output | 1 | Field was all zeros before modification |

## Verification
Every offset is swept against every width code for every operation, over windows that are all zeros, all ones, sparse or dense. Together these reach several corner cases:

- The 32-bit width code reaches the 64-bit shift limit. There, a mask built naively as one shifted left by the width wraps to an empty field.
- Fields that end at bit 1 or that cross bit 32 show up as half-written fields when the shifter is aligned wrongly.
- Empty fields for the search show whether a design returns 32 instead of the field width.
- Sign extension at a width of one bit shows up as a result with only bit 0 set.
- Checks on the hold cycle after each result catch outputs that reload without a strobe.

// File: rtl/bfPkg.sv
package bfPkg;

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_FFO  = 3'd2,
    OP_TST  = 3'd3,
    OP_INS  = 3'd4,
    OP_INV  = 3'd5,
    OP_CLR  = 3'd6,
    OP_SET  = 3'd7
  } bfOp_e;

  typedef enum logic [2:0] {
    FM_KEEP,
    FM_INS,
    FM_INV,
    FM_CLR,
    FM_SET
  } fieldMode_e;

  typedef enum logic [1:0] {
    RS_FIELD,
    RS_SIGNED,
    RS_FIRST
  } resSel_e;

  typedef struct packed {
    logic       load;
    fieldMode_e fieldMode;
    resSel_e    resSel;
  } bfStrobe_t;

endpackage

// File: rtl/bfLeadCount.sv
module bfLeadCount #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] count
);

  // Zeros ahead of the first 1, scanning from the MSB; W when vec is zero.
  always_comb begin
    logic found;
    found = 1'b0;
    count = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (!found && vec[W-1-i]) begin
        count = CNT_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bfCtrl.sv
module bfCtrl
  import bfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opCode,
  output bfStrobe_t  strobe,
  output logic       doneValid
);

  always_comb begin
    strobe.load      = inValid;
    strobe.fieldMode = FM_KEEP;
    strobe.resSel    = RS_FIELD;
    unique case (bfOp_e'(opCode))
      OP_EXTU: strobe.resSel = RS_FIELD;
      OP_EXTS: strobe.resSel = RS_SIGNED;
      OP_FFO:  strobe.resSel = RS_FIRST;
      OP_TST:  strobe.resSel = RS_FIELD;
      OP_INS:  strobe.fieldMode = FM_INS;
      OP_INV:  strobe.fieldMode = FM_INV;
      OP_CLR:  strobe.fieldMode = FM_CLR;
      OP_SET:  strobe.fieldMode = FM_SET;
      default: strobe.resSel = RS_FIELD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneValid <= 1'b0;
    else       doneValid <= inValid;
  end

endmodule

// File: rtl/bfDatapath.sv
module bfDatapath
  import bfPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int CNT_W = OFF_W + 1,
  localparam int WIN_W = 2 * DATA_W,
  localparam int SH_W  = $clog2(WIN_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfStrobe_t         strobe,
  input  logic [OFF_W-1:0]  bitOffset,
  input  logic [OFF_W-1:0]  fieldWidth,
  input  logic [WIN_W-1:0]  window,
  input  logic [DATA_W-1:0] insertVal,
  output logic [WIN_W-1:0]  winOut,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ
);

  logic [CNT_W-1:0]  widthFull;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] lowMask;
  logic [WIN_W-1:0]  winMask;
  logic [WIN_W-1:0]  insWide;
  logic [DATA_W-1:0] fieldVal;
  logic [OFF_W-1:0]  topIdx;
  logic              topBit;
  logic [DATA_W-1:0] signedVal;
  logic [DATA_W-1:0] leftAligned;
  logic [CNT_W-1:0]  leadZeros;
  logic [CNT_W-1:0]  ffoIdx;
  logic [DATA_W-1:0] ffoRes;
  logic [WIN_W-1:0]  newWin;
  logic [DATA_W-1:0] newRes;

  // Width code zero stands for the full word.
  assign widthFull = (fieldWidth == '0) ? CNT_W'(DATA_W) : {1'b0, fieldWidth};
  // Number of window bits below the field's least significant bit.
  assign shAmt   = SH_W'(WIN_W) - SH_W'(bitOffset) - SH_W'(widthFull);
  assign lowMask = (widthFull == CNT_W'(DATA_W)) ? '1
                 : ((DATA_W'(1) << widthFull) - DATA_W'(1));
  assign winMask = {{DATA_W{1'b0}}, lowMask} << shAmt;
  assign insWide = {{DATA_W{1'b0}}, insertVal & lowMask} << shAmt;

  assign fieldVal  = DATA_W'(window >> shAmt) & lowMask;
  assign topIdx    = OFF_W'(widthFull - CNT_W'(1));
  assign topBit    = fieldVal[topIdx];
  assign signedVal = topBit ? (fieldVal | ~lowMask) : fieldVal;

  // Search: move the field to the top of a word and count leading zeros.
  assign leftAligned = fieldVal << (CNT_W'(DATA_W) - widthFull);

  bfLeadCount #(.W(DATA_W)) u_lead (
    .vec   (leftAligned),
    .count (leadZeros)
  );

  assign ffoIdx = (fieldVal == '0) ? widthFull : leadZeros;
  assign ffoRes = DATA_W'(bitOffset) + DATA_W'(ffoIdx);

  always_comb begin
    unique case (strobe.fieldMode)
      FM_INS:  newWin = (window & ~winMask) | insWide;
      FM_INV:  newWin = window ^ winMask;
      FM_CLR:  newWin = window & ~winMask;
      FM_SET:  newWin = window | winMask;
      default: newWin = window;
    endcase
  end

  always_comb begin
    unique case (strobe.resSel)
      RS_SIGNED: newRes = signedVal;
      RS_FIRST:  newRes = ffoRes;
      default:   newRes = fieldVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOut <= '0;
      result <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
    end else if (strobe.load) begin
      winOut <= newWin;
      result <= newRes;
      flagN  <= topBit;
      flagZ  <= (fieldVal == '0);
    end
  end

endmodule

// File: rtl/bitFieldUnit.sv
module bitFieldUnit
  import bfPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int WIN_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opCode,
  input  logic [OFF_W-1:0]  bitOffset,
  input  logic [OFF_W-1:0]  fieldWidth,
  input  logic [WIN_W-1:0]  window,
  input  logic [DATA_W-1:0] insertVal,
  output logic              doneValid,
  output logic [WIN_W-1:0]  winOut,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ
);

  bfStrobe_t strobe;

  bfCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opCode    (opCode),
    .strobe    (strobe),
    .doneValid (doneValid)
  );

  bfDatapath #(.DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bitOffset  (bitOffset),
    .fieldWidth (fieldWidth),
    .window     (window),
    .insertVal  (insertVal),
    .winOut     (winOut),
    .result     (result),
    .flagN      (flagN),
    .flagZ      (flagZ)
  );

endmodule

// File: rtl/bfCheck.sv
module bfCheck #(
  parameter int DATA_W = 32,
  localparam int WIN_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        opCode,
  input logic [WIN_W-1:0]  window,
  input logic              doneValid,
  input logic [WIN_W-1:0]  winOut,
  input logic [DATA_W-1:0] result,
  input logic              flagN,
  input logic              flagZ
);

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> doneValid);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !doneValid);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(winOut) && $stable(flagN) && $stable(flagZ)));

  assert_read_ops_keep_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode <= 3'd3)) |=> (winOut == $past(window)));

  assert_zero_flag_extract_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd0) |=> (flagZ == (result == '0)));

  assert_sign_flag_extract_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd1) |=> (flagN == result[DATA_W-1]));

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rstN |=> (!doneValid && result == '0 && winOut == '0 && !flagN && !flagZ));

endmodule

bind bitFieldUnit bfCheck #(.DATA_W(DATA_W)) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opCode    (opCode),
  .window    (window),
  .doneValid (doneValid),
  .winOut    (winOut),
  .result    (result),
  .flagN     (flagN),
  .flagZ     (flagZ)
);

// File: tb/bitFieldUnit_tb.sv
`timescale 1ns/1ps
module bitFieldUnit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [4:0]  bitOffset = '0;
  logic [4:0]  fieldWidth = '0;
  logic [63:0] window = '0;
  logic [31:0] insertVal = '0;
  logic        doneValid;
  logic [63:0] winOut;
  logic [31:0] result;
  logic        flagN;
  logic        flagZ;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [63:0] rngState = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  bitFieldUnit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .bitOffset(bitOffset), .fieldWidth(fieldWidth), .window(window),
    .insertVal(insertVal), .doneValid(doneValid), .winOut(winOut),
    .result(result), .flagN(flagN), .flagZ(flagZ)
  );

  function automatic logic [63:0] nextRand();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >> 7);
    rngState = rngState ^ (rngState << 17);
    return rngState;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Bitwise reference: field bit k (k=0 is the field MSB) is window bit 63-off-k.
  task automatic model(input int op, input int off, input int wCode, input logic [63:0] win,
                       input logic [31:0] ins, output logic [63:0] eWin,
                       output logic [31:0] eRes, output bit eN, output bit eZ);
    int w;
    logic [31:0] fld;
    bit found;
    w = (wCode == 0) ? 32 : wCode;
    fld = '0;
    for (int k = 0; k < w; k++) fld = {fld[30:0], win[63-off-k]};
    eN = fld[w-1];
    eZ = (fld == '0);
    eWin = win;
    eRes = fld;
    case (op)
      1: for (int b = w; b < 32; b++) eRes[b] = eN;
      2: begin
        eRes = 32'(off + w);
        found = 0;
        for (int k = 0; k < w; k++)
          if (!found && win[63-off-k]) begin eRes = 32'(off + k); found = 1; end
      end
      4: for (int k = 0; k < w; k++) eWin[63-off-k] = ins[w-1-k];
      5: for (int k = 0; k < w; k++) eWin[63-off-k] = ~win[63-off-k];
      6: for (int k = 0; k < w; k++) eWin[63-off-k] = 1'b0;
      7: for (int k = 0; k < w; k++) eWin[63-off-k] = 1'b1;
      default: ;
    endcase
  endtask

  function automatic string reqForOp(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R8";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic runOp(input int op, input int off, input int wCode,
                       input logic [63:0] win, input logic [31:0] ins);
    logic [63:0] eWin;
    logic [31:0] eRes;
    bit eN, eZ;
    string rq;
    model(op, off, wCode, win, ins, eWin, eRes, eN, eZ);
    rq = reqForOp(op);
    @(negedge clk);
    opCode = 3'(op); bitOffset = 5'(off); fieldWidth = 5'(wCode);
    window = win; insertVal = ins; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    window = ~win; insertVal = ~ins;
    check(doneValid == 1'b1, "R10 done", 64'(doneValid), 64'd1);
    check(winOut == eWin, {rq, " R1 window"}, winOut, eWin);
    check(result == eRes, {rq, " R2 result"}, 64'(result), 64'(eRes));
    check(flagN == eN, "R9 N", 64'(flagN), 64'(eN));
    check(flagZ == eZ, "R9 Z", 64'(flagZ), 64'(eZ));
    @(negedge clk);
    check(doneValid == 1'b0, "R10 done drop", 64'(doneValid), 64'd0);
    check(result == eRes && winOut == eWin, "R10 hold", 64'(result), 64'(eRes));
  endtask

  initial begin
    logic [63:0] win;
    int pat;
    #5;
    @(negedge clk);
    check(doneValid == 1'b0, "R11 done", 64'(doneValid), 64'd0);
    check(winOut == '0, "R11 window", winOut, 64'd0);
    check(result == '0, "R11 result", 64'(result), 64'd0);
    check(flagN == 1'b0 && flagZ == 1'b0, "R11 flags", {62'd0, flagN, flagZ}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    pat = 0;
    for (int op = 0; op < 8; op++) begin
      for (int off = 0; off < 32; off++) begin
        for (int wc = 0; wc < 32; wc++) begin
          case (pat % 5)
            0: win = '0;
            1: win = '1;
            2: win = nextRand() & nextRand() & nextRand();
            default: win = nextRand();
          endcase
          pat++;
          runOp(op, off, wc, win, nextRand()[31:0]);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule